// File: doc/BRIEF.md
# Next-Fetch-Address Predictor with Target Buffer

This block chooses the address a single-issue fetch stage uses in the next cycle. The current fetch address probes a direct-mapped, tagged target buffer. A hit is the only thing that marks the fetched word as a branch; no decode is needed for this. Each entry keeps three things: the target seen the last time that branch ran, a two-bit branch kind, and a two-bit saturating direction counter. When an entry hits and its counter leans taken, the stored target becomes the next fetch address. In every other case the next address is the current one plus the instruction size.

The back end reports every resolved branch on a resolve port. A report that hits in the buffer trains the entry: it steps the counter, refreshes the kind and, if the branch was taken, replaces the target. A report that misses allocates the entry at that index. When the back end flags a report as mispredicted, the block raises a redirect carrying the correct address. In that same cycle the redirect overrides the predicted next address.

Top module: `nfa_predictor`

## Requirements
- R1: When the buffer misses and no redirect is active, `pred_hit` is 0 and `next_pc` equals `fetch_pc + 4` in the same cycle.
- R2: A hit needs a valid entry at index `fetch_pc[7:2]` whose stored tag equals `fetch_pc[31:8]`. A fetch address with the same index and a different tag misses.
- R3: On a hit with no redirect, a counter value of 2'b10 or 2'b11 drives `pred_taken` high and makes `next_pc` the stored target. A value of 2'b00 or 2'b01 drives `pred_taken` low and makes `next_pc` equal `fetch_pc + 4`.
- R4: A resolve report that hits raises the entry's counter by one when the branch was taken and lowers it by one when it was not taken. The counter stops at 2'b11 and at 2'b00.
- R5: A resolve report that misses allocates the entry. The counter starts at 2'b10 for a taken branch and at 2'b01 for a not-taken branch. The entry stores the reported target and kind. Kind codes are 2'b00 conditional, 2'b01 unconditional jump or call, 2'b10 return, 2'b11 indirect. A hit returns the stored code on `pred_kind`.
- R6: A taken report that hits replaces the stored target. A not-taken report leaves the stored target unchanged. Every report that hits replaces the stored kind.
- R7: When `rsv_valid` and `rsv_mispredict` are both high, `redirect_valid` is 1 and `redirect_pc` is `rsv_target` if `rsv_taken` is high, otherwise `rsv_pc + 4`. In that same cycle `next_pc` equals `redirect_pc`. With no mispredicted report, `redirect_valid` is 0.
- R8: A cycle with `rst` high invalidates every entry. A resolve report changes the buffer at the clock edge that ends its cycle, so lookups see the change from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| next_pc | output | 32 | Address to fetch in the next cycle |
| pred_hit | output | 1 | Buffer hit: the fetched word is a known branch |
| pred_taken | output | 1 | Hit whose counter predicts taken |
| pred_kind | output | 2 | Stored branch kind of the hitting entry |
| rsv_valid | input | 1 | A resolved branch is reported this cycle |
| rsv_pc | input | 32 | Address of the resolved branch |
| rsv_taken | input | 1 | Actual direction of the resolved branch |
| rsv_target | input | 32 | Actual target of the resolved branch |
| rsv_kind | input | 2 | Kind of the resolved branch |
| rsv_mispredict | input | 1 | Front end guessed direction or target wrongly |
| redirect_valid | output | 1 | Correction of the fetch stream is active |
| redirect_pc | output | 32 | Correct address when redirecting |

## Verification
The lookup outputs (`pred_hit`, `pred_taken`, `pred_kind`, `next_pc`) and the redirect outputs are combinational. The bench therefore drives its inputs on the falling edge and samples one nanosecond later, in the same cycle. A resolve report writes the buffer on the next rising edge. The bench holds each report for exactly one cycle, updates its own model of the entries, and probes the effect only from the following cycle. The same rule applies to reset, which is checked by sweeping every index right after it is released.

// File: rtl/btbp_pkg.sv
package btbp_pkg;

    typedef enum logic [1:0] {
        BK_COND = 2'b00,
        BK_JUMP = 2'b01,
        BK_RET  = 2'b10,
        BK_IND  = 2'b11
    } br_kind_e;

    typedef logic [1:0] sat2_t;

    localparam sat2_t SAT_WEAK_T = 2'b10;
    localparam sat2_t SAT_WEAK_N = 2'b01;

    typedef struct packed {
        logic     hit;
        logic     taken;
        br_kind_e kind;
    } probe_res_t;

    function automatic sat2_t sat2_step(sat2_t c, logic t);
        if (t) return (c == 2'b11) ? c : sat2_t'(c + 2'b01);
        return (c == 2'b00) ? c : sat2_t'(c - 2'b01);
    endfunction

    function automatic sat2_t sat2_seed(logic t);
        return t ? SAT_WEAK_T : SAT_WEAK_N;
    endfunction

    function automatic logic sat2_leans_taken(sat2_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/btb_table.sv
module btb_table
    import btbp_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int TAG_W = 24,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PC_W-1:0]  rd_tgt,
    output br_kind_e         rd_kind,
    output sat2_t            rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_taken,
    input  logic [PC_W-1:0]  wr_tgt,
    input  br_kind_e         wr_kind
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;
    logic [TAG_W-1:0] tag_q  [DEPTH];
    logic [PC_W-1:0]  tgt_q  [DEPTH];
    br_kind_e         kind_q [DEPTH];
    sat2_t            ctr_q  [DEPTH];

    logic wr_hit;
    assign wr_hit = vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);

    assign rd_vld  = vld_q[rd_idx];
    assign rd_tag  = tag_q[rd_idx];
    assign rd_tgt  = tgt_q[rd_idx];
    assign rd_kind = kind_q[rd_idx];
    assign rd_ctr  = ctr_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_en) begin
            kind_q[wr_idx] <= wr_kind;
            if (wr_hit) begin
                ctr_q[wr_idx] <= sat2_step(ctr_q[wr_idx], wr_taken);
                if (wr_taken) tgt_q[wr_idx] <= wr_tgt;
            end else begin
                tag_q[wr_idx] <= wr_tag;
                tgt_q[wr_idx] <= wr_tgt;
                ctr_q[wr_idx] <= sat2_seed(wr_taken);
            end
        end
    end

    logic [IDX_W-1:0] chk_idx_q;
    always_ff @(posedge clk) chk_idx_q <= wr_idx;

    // R8
    reset_clears_chk: assert property (@(posedge clk) rst |=> (vld_q == '0));

    // R4
    sat_top_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_hit && wr_taken && ctr_q[wr_idx] == 2'b11) |=> (ctr_q[chk_idx_q] == 2'b11));

    // R4
    sat_bottom_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_hit && !wr_taken && ctr_q[wr_idx] == 2'b00) |=> (ctr_q[chk_idx_q] == 2'b00));

    // R5
    alloc_seed_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_hit) |=> (vld_q[chk_idx_q] && ctr_q[chk_idx_q] inside {2'b01, 2'b10}));

endmodule

// File: rtl/btb_probe.sv
module btb_probe
    import btbp_pkg::*;
#(
    parameter int TAG_W = 24
) (
    input  logic             rd_vld,
    input  logic [TAG_W-1:0] rd_tag,
    input  br_kind_e         rd_kind,
    input  sat2_t            rd_ctr,
    input  logic [TAG_W-1:0] want_tag,
    output probe_res_t       res
);
    always_comb begin
        res.hit   = rd_vld && (rd_tag == want_tag);
        res.taken = res.hit && sat2_leans_taken(rd_ctr);
        res.kind  = rd_kind;
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import btbp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int STEP  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    input  probe_res_t      res,
    input  logic [PC_W-1:0] rd_tgt,
    input  logic            rsv_valid,
    input  logic            rsv_mispredict,
    input  logic            rsv_taken,
    input  logic [PC_W-1:0] rsv_pc,
    input  logic [PC_W-1:0] rsv_target,
    output logic [PC_W-1:0] next_pc,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc
);
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] guess_pc;

    always_comb begin
        seq_pc         = fetch_pc + PC_W'(STEP);
        guess_pc       = res.taken ? rd_tgt : seq_pc;
        redirect_valid = rsv_valid && rsv_mispredict;
        redirect_pc    = rsv_taken ? rsv_target : rsv_pc + PC_W'(STEP);
        next_pc        = redirect_valid ? redirect_pc : guess_pc;
    end

    // R7
    redirect_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (rsv_valid && rsv_mispredict && rsv_taken) |-> (next_pc == rsv_target));

    // R1
    miss_sequential_chk: assert property (@(posedge clk) disable iff (rst)
        (!res.hit && !(rsv_valid && rsv_mispredict)) |-> (next_pc == fetch_pc + PC_W'(STEP)));

endmodule

// File: rtl/nfa_predictor.sv
module nfa_predictor
    import btbp_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int IDX_W      = 6,
    parameter int INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] next_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [1:0]      pred_kind,
    input  logic            rsv_valid,
    input  logic [PC_W-1:0] rsv_pc,
    input  logic            rsv_taken,
    input  logic [PC_W-1:0] rsv_target,
    input  logic [1:0]      rsv_kind,
    input  logic            rsv_mispredict,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc
);
    localparam int OFF_W = $clog2(INSN_BYTES);
    localparam int TAG_W = PC_W - IDX_W - OFF_W;

    logic [IDX_W-1:0] f_idx, r_idx;
    logic [TAG_W-1:0] f_tag, r_tag;
    assign f_idx = fetch_pc[OFF_W +: IDX_W];
    assign f_tag = fetch_pc[PC_W-1 -: TAG_W];
    assign r_idx = rsv_pc[OFF_W +: IDX_W];
    assign r_tag = rsv_pc[PC_W-1 -: TAG_W];

    logic             rd_vld;
    logic [TAG_W-1:0] rd_tag;
    logic [PC_W-1:0]  rd_tgt;
    br_kind_e         rd_kind;
    sat2_t            rd_ctr;
    probe_res_t       res;

    btb_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_table (
        .clk(clk), .rst(rst),
        .rd_idx(f_idx), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_tgt(rd_tgt),
        .rd_kind(rd_kind), .rd_ctr(rd_ctr),
        .wr_en(rsv_valid), .wr_idx(r_idx), .wr_tag(r_tag), .wr_taken(rsv_taken),
        .wr_tgt(rsv_target), .wr_kind(br_kind_e'(rsv_kind))
    );

    btb_probe #(.TAG_W(TAG_W)) u_probe (
        .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_kind(rd_kind), .rd_ctr(rd_ctr),
        .want_tag(f_tag), .res(res)
    );

    npc_select #(.PC_W(PC_W), .STEP(INSN_BYTES)) u_sel (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .res(res), .rd_tgt(rd_tgt),
        .rsv_valid(rsv_valid), .rsv_mispredict(rsv_mispredict), .rsv_taken(rsv_taken),
        .rsv_pc(rsv_pc), .rsv_target(rsv_target),
        .next_pc(next_pc), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    assign pred_hit   = res.hit;
    assign pred_taken = res.taken;
    assign pred_kind  = res.kind;

endmodule

// File: tb/sim_nfa_predictor.sv
module sim_nfa_predictor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic [31:0] next_pc;
    logic        pred_hit, pred_taken;
    logic [1:0]  pred_kind;
    logic        rsv_valid = 1'b0;
    logic [31:0] rsv_pc = '0;
    logic        rsv_taken = 1'b0;
    logic [31:0] rsv_target = '0;
    logic [1:0]  rsv_kind = '0;
    logic        rsv_mispredict = 1'b0;
    logic        redirect_valid;
    logic [31:0] redirect_pc;

    always #2 clk = ~clk;

    nfa_predictor u0 (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .next_pc(next_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_kind(pred_kind),
        .rsv_valid(rsv_valid), .rsv_pc(rsv_pc), .rsv_taken(rsv_taken),
        .rsv_target(rsv_target), .rsv_kind(rsv_kind), .rsv_mispredict(rsv_mispredict),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic        m_vld [64];
    logic [23:0] m_tag [64];
    logic [31:0] m_tgt [64];
    logic [1:0]  m_kind[64];
    logic [1:0]  m_ctr [64];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
    endtask

    function automatic logic [31:0] mk_pc(input logic [23:0] tg, input int idx);
        return {tg, 6'(idx), 2'b00};
    endfunction

    task automatic model_resolve(input logic [31:0] pc, input logic tk,
                                 input logic [31:0] tgt, input logic [1:0] kd);
        int ix = int'(pc[7:2]);
        if (m_vld[ix] && m_tag[ix] == pc[31:8]) begin
            if (tk) m_ctr[ix] = (m_ctr[ix] == 2'b11) ? 2'b11 : m_ctr[ix] + 2'b01;
            else    m_ctr[ix] = (m_ctr[ix] == 2'b00) ? 2'b00 : m_ctr[ix] - 2'b01;
            if (tk) m_tgt[ix] = tgt;
        end else begin
            m_vld[ix] = 1'b1;
            m_tag[ix] = pc[31:8];
            m_tgt[ix] = tgt;
            m_ctr[ix] = tk ? 2'b10 : 2'b01;
        end
        m_kind[ix] = kd;
    endtask

    // Probe one fetch address against the model; caller is at a falling edge.
    task automatic lookup(input logic [31:0] pc, input string req);
        int ix = int'(pc[7:2]);
        logic hit, tk;
        fetch_pc = pc;
        #1;
        hit = m_vld[ix] && (m_tag[ix] == pc[31:8]);
        tk  = hit && m_ctr[ix][1];
        chk({req, " hit"}, 32'(pred_hit), 32'(hit));
        chk({req, " taken"}, 32'(pred_taken), 32'(tk));
        chk({req, " next_pc"}, next_pc, tk ? m_tgt[ix] : pc + 32'd4);
        if (hit) chk({req, " kind"}, 32'(pred_kind), 32'(m_kind[ix]));
        @(negedge clk);
    endtask

    // One-cycle resolve report; optional same-cycle redirect check.
    task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt,
                           input logic [1:0] kd, input logic misp);
        rsv_valid = 1'b1; rsv_pc = pc; rsv_taken = tk; rsv_target = tgt;
        rsv_kind = kd; rsv_mispredict = misp;
        #1;
        // R7
        chk("R7 redirect_valid", 32'(redirect_valid), 32'(misp));
        if (misp) begin
            chk("R7 redirect_pc", redirect_pc, tk ? tgt : pc + 32'd4);
            chk("R7 next_pc override", next_pc, tk ? tgt : pc + 32'd4);
        end
        @(negedge clk);
        rsv_valid = 1'b0; rsv_mispredict = 1'b0;
        model_resolve(pc, tk, tgt, kd);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8 / R1: every index misses after reset
        for (int i = 0; i < 64; i++) lookup(mk_pc(24'h00A5C3, i), "R1 R8 post-reset");

        // R5: allocate every index with a mix of direction and kind
        for (int i = 0; i < 64; i++)
            resolve(mk_pc(24'h00A5C3, i), i[0], 32'h4000_0000 + 32'(i * 16), 2'(i >> 1), 1'b0);
        for (int i = 0; i < 64; i++) lookup(mk_pc(24'h00A5C3, i), "R5 R3 allocated");

        // R4 / R6 / R3: outcome sequences drive counters through all states
        for (int i = 0; i < 16; i++) begin
            logic [7:0] pat = 8'(i * 29 + 3);
            for (int k = 0; k < 6; k++) begin
                resolve(mk_pc(24'h00A5C3, i), pat[k],
                        32'h5000_0000 + 32'(i * 256 + k * 4), 2'(k), 1'b0);
                lookup(mk_pc(24'h00A5C3, i), "R4 R6 training");
            end
        end
        // R4: long runs to both saturation ends
        for (int k = 0; k < 5; k++) resolve(mk_pc(24'h00A5C3, 20), 1'b1, 32'h6000_0000, 2'b00, 1'b0);
        lookup(mk_pc(24'h00A5C3, 20), "R4 saturate high");
        resolve(mk_pc(24'h00A5C3, 20), 1'b0, 32'h0, 2'b00, 1'b0);
        lookup(mk_pc(24'h00A5C3, 20), "R4 one miss from strong");
        for (int k = 0; k < 5; k++) resolve(mk_pc(24'h00A5C3, 20), 1'b0, 32'h0, 2'b00, 1'b0);
        lookup(mk_pc(24'h00A5C3, 20), "R4 saturate low");
        resolve(mk_pc(24'h00A5C3, 20), 1'b1, 32'h6100_0000, 2'b00, 1'b0);
        lookup(mk_pc(24'h00A5C3, 20), "R4 R6 one taken from strong low");

        // R2: same index, different tag misses; then replaces
        lookup(mk_pc(24'h123456, 30), "R2 alias miss");
        resolve(mk_pc(24'h123456, 30), 1'b1, 32'h7000_0040, 2'b11, 1'b0);
        lookup(mk_pc(24'h123456, 30), "R2 alias allocated");
        lookup(mk_pc(24'h00A5C3, 30), "R2 old tag evicted");

        // R7: redirects, taken and not taken, with fetch hitting a taken entry
        fetch_pc = mk_pc(24'h00A5C3, 41);
        resolve(mk_pc(24'h00BEEF, 50), 1'b1, 32'h8000_1000, 2'b01, 1'b1);
        resolve(mk_pc(24'h00BEEF, 50), 1'b0, 32'h8000_2000, 2'b00, 1'b1);
        resolve(mk_pc(24'h00BEEF, 51), 1'b1, 32'h8000_3000, 2'b10, 1'b0);
        lookup(mk_pc(24'h00BEEF, 50), "R7 R4 after redirect training");

        // R8: reset again and sweep
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        for (int i = 0; i < 64; i++) lookup(mk_pc(24'h00A5C3, i), "R8 second reset");

        finish_run();
    end
endmodule